// File: doc/BRIEF.md
# Count-Source Timer Core

This block is a 32-bit timer/counter clocked by the bus clock. A prescale counter sits in front of a timer counter. Each "advance" bumps the prescale counter. When the prescale counter reaches the programmed prescale value, it returns to zero and the timer counter steps by one.

The advance source is chosen by a control byte. In timer mode the advance comes from every bus clock edge while running. In counter mode it comes from rising, falling or both edges of one of four asynchronous capture inputs. Separately, a selected edge on a capture channel can clear both counters synchronously, which restarts a measurement from an external event.

Software programs the block through a small write/read port. The port holds three registers: the control byte, the prescale value, and a run word with a run enable and a hold-at-zero bit. The timer count is also readable there and appears directly on an output.

Top module: `count_timer`

## Requirements
- R1: After reset, the control byte, prescale value, run word and timer count all read zero. Register addresses are 0 control, 1 prescale, 2 run word (bit 0 run, bit 1 hold-zero) and 3 timer count (read-only).
- R2: With control bits 1:0 equal to 0 (timer mode) and run set, every rising clock edge is one advance.
- R3: An advance with the prescale counter equal to the prescale value clears the prescale counter and increments the timer count. Any other advance increments the prescale counter. So after A advances from zero, the count is A/(P+1).
- R4: Mode value 1 advances once per rising edge of the selected capture input.
- R5: Mode value 2 advances once per falling edge of the selected capture input.
- R6: Mode value 3 advances on both edges of the selected capture input.
- R7: Control bits 3:2 pick capture channel 0 to 3 as the count source. Edges on the other channels do not advance the counters.
- R8: While run is clear, no advance happens and the timer count holds.
- R9: While hold-zero is set, both counters are held at zero.
- R10: With control bit 4 set, the edge named by control bits 7:5 clears both counters. In that field, value 2k+0 means a rising edge and 2k+1 a falling edge of channel k, for k = 0 to 2. The clear acts regardless of run, and it wins over an advance in the same cycle.
- R11: With control bit 4 clear, or with bits 7:5 equal to 6 or 7, no capture edge clears the counters.
- R12: The timer count wraps from all ones to zero.
- R13: Each capture input passes through two synchronizing flops and then an edge detector. A level change driven before clock edge 1 takes effect on the counters at clock edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_in | input | 4 | Asynchronous capture inputs, channels 0 to 3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DW (32) | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DW (32) | Register read data, combinational |
| tc_value | output | TC_W (32) | Current timer count |

## Verification
Timer mode is run for fixed spans with prescale values 0 and 3. These runs separate per-clock counting from the prescale divide, and a long span shows the wrap. In counter mode, random toggle sequences are spread across all four channels, with random mode, channel and prescale. The resulting count shows whether only the selected channel counts and only the qualified edge polarity does. Directed cases then pin the exact timing: a single input change lands at the third clock edge. A clear placed in the middle of a timer-mode run leaves an exact residue that fixes when the clear happens and shows it beats the advance. Reserved and disabled edge selects leave the full count standing.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
// Shared types for the count-source timer: mode encoding and control byte layout.
// Assumes a 2-bit channel field, so the capture channel count is fixed at four.
package tcc_pkg;
    localparam int CAP_N = 4;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_BOTH = 2'd3
    } src_mode_e;

    // Packed MSB first: bits 7:5 clear select, 4 clear enable, 3:2 channel, 1:0 mode.
    typedef struct packed {
        logic [2:0] clr_sel;
        logic       clr_en;
        logic [1:0] chan;
        src_mode_e  mode;
    } ctrl_t;
endpackage

// File: rtl/tcc_edge_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer plus edge detector for each capture channel.
// Assumes each input level is held at least two clock periods so that no edge is lost.
module tcc_edge_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic meta_q, sync_q, prev_q;

        // Resynchronize the channel and keep one older sample for edge compare.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign rise[g] = sync_q & ~prev_q;
        assign fall[g] = ~sync_q & prev_q;
    end
endmodule

// File: rtl/tcc_event_sel.sv
`timescale 1ns/1ps
// Turns the control byte and the detected edges into an advance pulse and a clear pulse.
// Assumes edge pulses are single-cycle. Clear-select codes 6 and 7 are treated as inert.
module tcc_event_sel
    import tcc_pkg::*;
#(
    parameter int N = CAP_N
) (
    input  ctrl_t        ctrl,
    input  logic         run,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] fall,
    output logic         adv,
    output logic         clr_evt
);
    logic       src_rise, src_fall, src_hit;
    logic [1:0] clr_ch;
    logic       clr_ok;

    // Qualify the count-source edge according to the mode field.
    always_comb begin
        src_rise = rise[ctrl.chan];
        src_fall = fall[ctrl.chan];
        unique case (ctrl.mode)
            SRC_CLK:  src_hit = 1'b1;
            SRC_RISE: src_hit = src_rise;
            SRC_FALL: src_hit = src_fall;
            default:  src_hit = src_rise | src_fall;
        endcase
        adv = run & src_hit;
    end

    // Decode the clear-select field into a channel and polarity, gated by the enable.
    always_comb begin
        clr_ch  = ctrl.clr_sel[2:1];
        clr_ok  = ctrl.clr_en && (clr_ch != 2'b11);
        clr_evt = clr_ok && (ctrl.clr_sel[0] ? fall[clr_ch] : rise[clr_ch]);
    end
endmodule

// File: rtl/tcc_counters.sv
`timescale 1ns/1ps
// Prescale counter feeding a wrapping timer counter.
// Assumes the clear input already merges the edge clear and the hold-zero request.
module tcc_counters #(
    parameter int PS_W = 32,
    parameter int TC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            clr,
    input  logic [PS_W-1:0] limit,
    output logic [TC_W-1:0] tc
);
    logic [PS_W-1:0] pc_q;

    // Clear has priority. Otherwise an advance steps the prescaler or rolls into the timer count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            tc   <= '0;
        end else if (clr) begin
            pc_q <= '0;
            tc   <= '0;
        end else if (adv) begin
            if (pc_q == limit) begin
                pc_q <= '0;
                tc   <= tc + TC_W'(1);
            end else begin
                pc_q <= pc_q + PS_W'(1);
            end
        end
    end
endmodule

// File: rtl/count_timer.sv
`timescale 1ns/1ps
// Count-source timer top: register port, capture synchronizers, event selection, counters.
// Assumes PS_W and TC_W do not exceed DW. Register reads are combinational.
module count_timer
    import tcc_pkg::*;
#(
    parameter int DW   = 32,
    parameter int PS_W = 32,
    parameter int TC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAP_N-1:0] cap_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [1:0]       rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [TC_W-1:0]  tc_value
);
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_PRE  = 2'd1;
    localparam logic [1:0] A_RUN  = 2'd2;
    localparam logic [1:0] A_TC   = 2'd3;

    ctrl_t            ctrl_q;
    logic [PS_W-1:0]  prescale_q;
    logic             run_q, zero_q;
    logic [CAP_N-1:0] rise, fall;
    logic             adv, clr_evt;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    // Capture software writes into the control, prescale and run registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            prescale_q <= '0;
            run_q      <= 1'b0;
            zero_q     <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:  ctrl_q     <= ctrl_t'(wr_data[7:0]);
                A_PRE:   prescale_q <= wr_data[PS_W-1:0];
                A_RUN:   begin
                    run_q  <= wr_data[0];
                    zero_q <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    // Return the addressed register, zero-extended to the data width.
    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = DW'(ctrl_q);
            A_PRE:   rd_data = DW'(prescale_q);
            A_RUN:   rd_data = DW'({zero_q, run_q});
            A_TC:    rd_data = DW'(tc_value);
            default: rd_data = '0;
        endcase
    end

    tcc_edge_sync #(.N(CAP_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cap_in),
        .rise     (rise),
        .fall     (fall)
    );

    tcc_event_sel #(.N(CAP_N)) u_sel (
        .ctrl    (ctrl_q),
        .run     (run_q),
        .rise    (rise),
        .fall    (fall),
        .adv     (adv),
        .clr_evt (clr_evt)
    );

    tcc_counters #(.PS_W(PS_W), .TC_W(TC_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .clr   (clr_evt | zero_q),
        .limit (prescale_q),
        .tc    (tc_value)
    );
endmodule

// File: rtl/tcc_checker.sv
`timescale 1ns/1ps
// Property checker for the count-source timer, attached to every count_timer by bind.
module tcc_checker #(
    parameter int TC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      ctrl,
    input logic            run,
    input logic            zero,
    input logic            adv,
    input logic            clr_evt,
    input logic [TC_W-1:0] tc
);
    // R10: a clear event leaves the timer count at zero on the next cycle.
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (tc == '0));

    // R9: hold-zero forces the count to zero.
    a_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        zero |=> (tc == '0));

    // R8: with run clear and no clearing source, the count does not move.
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !zero && !clr_evt) |=> $stable(tc));

    // R8: no advance is produced while run is clear.
    a_r8_no_adv: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !adv);

    // R3 / R12: without a clear, the count stays or steps by one, modulo its width.
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero && !clr_evt) |=> (tc == $past(tc) || tc == TC_W'($past(tc) + 1'b1)));

    // R11: a disabled or reserved clear select never produces a clear.
    a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[4] || ctrl[7:6] == 2'b11) |-> !clr_evt);
endmodule

bind count_timer tcc_checker #(.TC_W(TC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl_q),
    .run     (run_q),
    .zero    (zero_q),
    .adv     (adv),
    .clr_evt (clr_evt),
    .tc      (tc_value)
);

// File: tb/sim_count_timer.sv
`timescale 1ns/1ps
// Bench for count_timer: directed corner cases plus seeded random counter-mode trials.
module sim_count_timer;
    localparam int DW   = 32;
    localparam int PS_W = 8;
    localparam int TC_W = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cap = 4'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = 2'd0;
    logic [DW-1:0] rd_data;
    logic [TC_W-1:0] tc_value;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    count_timer #(.DW(DW), .PS_W(PS_W), .TC_W(TC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_in(cap), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tc_value(tc_value)
    );

    function automatic int exp_tc(int advances, int p);
        return (advances / (p + 1)) % (1 << TC_W);
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // All tasks are entered at a falling edge and return at a falling edge.
    task automatic wr(int addr, int data);
        wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int addr, output int v);
        rd_addr = addr[1:0];
        #1;
        v = int'(rd_data);
    endtask

    task automatic zero_cnt();
        wr(2, 2);
        wr(2, 0);
    endtask

    task automatic timer_span(int p, int n, string req);
        int v;
        wr(1, p); wr(0, 0); zero_cnt(); wr(2, 1);
        repeat (n) @(negedge clk);
        wr(2, 0);
        rd(3, v);
        check(req, v, exp_tc(n + 1, p));
    endtask

    task automatic rnd_trial(int mode, int ch, int p, int steps);
        int edges = 0;
        int v;
        wr(0, (ch << 2) | mode); wr(1, p); zero_cnt(); wr(2, 1);
        for (int s = 0; s < steps; s++) begin
            int c = int'($urandom % 4);
            int h = 3 + int'($urandom % 4);
            logic nv = ~cap[c];
            cap[c] = nv;
            if (c == ch) begin
                if (nv && mode != 2) edges++;
                if (!nv && mode != 1) edges++;
            end
            repeat (h) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        wr(2, 0);
        rd(3, v);
        check($sformatf("R4/R5/R6/R7 mode %0d ch %0d", mode, ch), v, exp_tc(edges, p));
    endtask

    // Clear test: run in timer mode, make one edge, and expect k-2 counts left after it.
    task automatic clear_run(int ctrl, int ch, logic lvl, int k, int exp, string req);
        int v;
        cap[ch] = ~lvl;
        repeat (5) @(negedge clk);
        wr(0, ctrl); wr(1, 0); zero_cnt(); wr(2, 1);
        repeat (20) @(negedge clk);
        cap[ch] = lvl;
        repeat (k) @(negedge clk);
        wr(2, 0);
        rd(3, v);
        check(req, v, exp);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        void'($urandom(32'h5eed_c0de));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values.
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            check($sformatf("R1 addr %0d", a), v, 0);
        end
        @(negedge clk);

        // R2: timer mode, prescale 0.
        timer_span(0, 40, "R2 timer mode");
        // R3: prescale divide by 4.
        timer_span(3, 40, "R3 prescale");
        // R8: count holds after run clears.
        repeat (6) @(negedge clk);
        rd(3, v);
        check("R8 hold while stopped", v, exp_tc(41, 3));
        // R12: wrap past all ones.
        timer_span(0, 1028, "R12 wrap");

        // R9: hold-zero while running.
        wr(1, 0); wr(0, 0); wr(2, 1);
        repeat (10) @(negedge clk);
        wr(2, 3);
        repeat (5) @(negedge clk);
        rd(3, v);
        check("R9 hold zero", v, 0);
        wr(2, 0);

        // R13: single rising edge on channel 1 lands at the third clock edge.
        wr(0, (1 << 2) | 1); wr(1, 0); zero_cnt(); wr(2, 1);
        cap[1] = 1'b1;
        repeat (2) @(negedge clk);
        rd(3, v);
        check("R13 not yet counted", v, 0);
        @(negedge clk);
        rd(3, v);
        check("R13 counted at third edge", v, 1);
        wr(2, 0);

        // R10: clear on channel 0 rising (select 0), and channel 2 falling (select 5).
        clear_run(8'h10, 0, 1'b1, 10, 8, "R10 clear ch0 rising");
        clear_run(8'hB0, 2, 1'b0, 7, 5, "R10 clear ch2 falling");
        // R10: wrong polarity on the selected channel does not clear.
        clear_run(8'h10, 0, 1'b0, 10, 31, "R10 opposite edge ignored");
        // R11: reserved select 6 and disabled clear leave the full count.
        clear_run(8'hD0, 3, 1'b1, 10, 31, "R11 reserved select");
        clear_run(8'h00, 0, 1'b1, 10, 31, "R11 clear disabled");

        // R4 R5 R6 R7: directed then random counter-mode trials.
        rnd_trial(1, 3, 0, 20);
        rnd_trial(2, 0, 0, 20);
        rnd_trial(3, 2, 1, 20);
        for (int t = 0; t < 24; t++) begin
            rnd_trial(1 + int'($urandom % 3), int'($urandom % 4),
                      int'($urandom % 3), 10 + int'($urandom % 21));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule